// File: doc/BRIEF.md
# Section Parity Checker

This block checks the section parity of a framed optical-transport byte stream. One byte arrives per clock. For every frame it builds an interleaved 8-bit even-parity code: each bit position is the XOR of that bit across all bytes of the frame. The code is taken from the stream as received, before descrambling. When the parity byte of the next frame arrives, the code is compared with that byte after descrambling.

The result leaves the block in two forms. The first is a serial train of fixed-width pulses on a single line, one pulse for each bit position that differs. The second is a registered count of the same value. A framer upstream supplies the frame strobe and the flag that marks the parity byte. A descrambler upstream supplies the descrambled copy of each byte. Framing and descrambling are not part of this block.

Assumptions: the parity-byte flag never coincides with the frame strobe. A frame is longer than the one-cycle report delay plus the longest pulse train, which is 2·PULSE_W·DATA_W cycles.

Top module: `sec_parity_chk`

## Requirements
- R1: The parity code of a frame is the bitwise XOR of every `scr_data` byte, starting with the byte that carries `frame_start` high and ending with the byte just before the next `frame_start`.
- R2: The code of a frame is compared with `dsc_data` in the cycle of the following frame in which `b1_flag` is high.
- R3: `err_cnt` takes the number of bit positions that differ (0 to 8) on the clock edge that samples `b1_flag` high. It holds that value until the next comparison. It never exceeds DATA_W.
- R4: The number of high pulses on `err_pulse` equals the mismatch count. A count of zero leaves `err_pulse` low, and a high `err_pulse` always comes with a non-zero `err_cnt`.
- R5: Each pulse is high for exactly PULSE_W clocks. Each pulse is followed by PULSE_W low clocks before the next pulse, or before the line goes idle.
- R6: The first pulse goes high on the clock edge that samples `b1_flag` high, so it is visible one cycle after the parity byte.
- R7: Bytes received before the first `frame_start` after reset have no effect on any parity code. The code of one frame has no effect on the code of any other frame.
- R8: A parity byte in the first frame after reset produces no report: `err_cnt` stays 0 and `err_pulse` stays low.
- R9: While `rst_n` is sampled low, `err_pulse` and `err_cnt` are 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | High on the first byte of each frame |
| scr_data | input | 8 | Received byte before descrambling |
| dsc_data | input | 8 | The same byte after descrambling |
| b1_flag | input | 1 | High when dsc_data carries the section parity byte |
| err_pulse | output | 1 | Pulse train, one pulse per mismatched bit |
| err_cnt | output | 4 | Mismatch count of the latest comparison |

## Verification
The bench builds the block with DATA_W = 8 and PULSE_W = 4. Halving the pulse width keeps the worst-case train, eight pulses, to 64 cycles, so 80-byte frames hold a full train and the sparsest and densest error patterns both fit in a short run. The error masks cover no errors, a single bit at either end of the byte, a mixed pattern and all eight bits. Frames of different lengths and junk bytes sent before the first frame exercise the per-frame seeding of the accumulator.

// File: rtl/bip_pkg.sv
// Package: shared sizing helpers for the section parity checker.
// Assumes widths are small positive integers.
package bip_pkg;

    // Bits needed to hold a count from 0 to w inclusive.
    function automatic int cnt_bits(input int w);
        return $clog2(w + 1);
    endfunction

    // Bits needed for a phase counter covering one high and one low interval.
    function automatic int phase_bits(input int w);
        return (w < 1) ? 1 : $clog2(2 * w);
    endfunction

endpackage

// File: rtl/bip_accum.sv
// Module: bip_accum
// Accumulates the interleaved even-parity code of each frame from the
// stream as received. On every frame strobe it hands the finished code of
// the previous frame to the comparator and seeds the accumulator with the
// current byte. It assumes one byte per clock.
module bip_accum #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [DATA_W-1:0] scr_data,
    output logic [DATA_W-1:0] ref_code,
    output logic              ref_valid
);

    logic [DATA_W-1:0] acc_q;
    logic              seen_q;

    // Running XOR, seeded on the first byte of every frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (frame_start) begin
            acc_q <= scr_data;
        end else begin
            acc_q <= acc_q ^ scr_data;
        end
    end

    // Captures the finished code and marks it valid once a whole frame was seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_code  <= '0;
            ref_valid <= 1'b0;
            seen_q    <= 1'b0;
        end else if (frame_start) begin
            ref_code  <= acc_q;
            ref_valid <= seen_q;
            seen_q    <= 1'b1;
        end
    end

endmodule

// File: rtl/bip_compare.sv
// Module: bip_compare
// Compares the stored code with the descrambled parity byte and counts the
// differing bit positions. It is purely combinational and assumes the
// parity-byte flag never lands on a frame-strobe cycle.
module bip_compare #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic [DATA_W-1:0] ref_code,
    input  logic              ref_valid,
    input  logic              b1_flag,
    input  logic [DATA_W-1:0] dsc_data,
    output logic              load,
    output logic [CNT_W-1:0]  mism
);

    logic [DATA_W-1:0] diff;

    // Marks a comparison only when a complete previous frame exists.
    always_comb begin
        load = b1_flag && ref_valid;
        diff = ref_code ^ dsc_data;
    end

    // Population count of the differing bits.
    always_comb begin
        mism = '0;
        for (int i = 0; i < DATA_W; i++) begin
            mism = mism + CNT_W'(diff[i]);
        end
    end

endmodule

// File: rtl/bip_pulse_gen.sv
// Module: bip_pulse_gen
// Registers the mismatch count and serialises it as a train of pulses,
// each PULSE_W clocks high followed by PULSE_W clocks low. A new load
// restarts the train. It assumes loads are spaced further apart than the
// longest train.
module bip_pulse_gen #(
    parameter int PULSE_W = 8,
    parameter int CNT_W   = 4,
    parameter int PH_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] mism,
    output logic             err_pulse,
    output logic [CNT_W-1:0] err_cnt
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * PULSE_W - 1);
    localparam logic [PH_W-1:0] PH_HIGH = PH_W'(PULSE_W);

    logic [CNT_W-1:0] rem_q;
    logic [PH_W-1:0]  ph_q;
    logic             active_q;

    // Holds the reported count until the next comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_cnt <= '0;
        end else if (load) begin
            err_cnt <= mism;
        end
    end

    // Walks the phase counter and the number of pulses still to send.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q    <= '0;
            ph_q     <= '0;
            active_q <= 1'b0;
        end else if (load) begin
            rem_q    <= mism;
            ph_q     <= '0;
            active_q <= (mism != '0);
        end else if (active_q) begin
            if (ph_q == PH_LAST) begin
                ph_q  <= '0;
                rem_q <= rem_q - 1'b1;
                if (rem_q == CNT_W'(1)) begin
                    active_q <= 1'b0;
                end
            end else begin
                ph_q <= ph_q + 1'b1;
            end
        end
    end

    // High during the first half of each pulse period.
    always_comb begin
        err_pulse = active_q && (ph_q < PH_HIGH);
    end

endmodule

// File: rtl/sec_parity_chk.sv
// Module: sec_parity_chk
// Top level of the section parity checker: accumulator, comparator and
// pulse generator. It assumes one byte per clock, a framer that supplies
// the frame strobe and parity-byte flag, and a descrambler that supplies
// the descrambled copy of each byte.
module sec_parity_chk #(
    parameter int DATA_W  = 8,
    parameter int PULSE_W = 8,
    localparam int CNT_W  = bip_pkg::cnt_bits(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [DATA_W-1:0] scr_data,
    input  logic [DATA_W-1:0] dsc_data,
    input  logic              b1_flag,
    output logic              err_pulse,
    output logic [CNT_W-1:0]  err_cnt
);

    localparam int PH_W = bip_pkg::phase_bits(PULSE_W);

    logic [DATA_W-1:0] ref_code;
    logic              ref_valid;
    logic              load;
    logic [CNT_W-1:0]  mism;

    bip_accum #(.DATA_W(DATA_W)) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .scr_data    (scr_data),
        .ref_code    (ref_code),
        .ref_valid   (ref_valid)
    );

    bip_compare #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_compare (
        .ref_code  (ref_code),
        .ref_valid (ref_valid),
        .b1_flag   (b1_flag),
        .dsc_data  (dsc_data),
        .load      (load),
        .mism      (mism)
    );

    bip_pulse_gen #(.PULSE_W(PULSE_W), .CNT_W(CNT_W), .PH_W(PH_W)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .mism      (mism),
        .err_pulse (err_pulse),
        .err_cnt   (err_cnt)
    );

endmodule

// File: rtl/sec_parity_chk_props.sv
// Module: sec_parity_chk_props
// Port-level properties of the section parity checker, bound to every
// instance of the top module. It assumes pulse trains do not overlap.
module sec_parity_chk_props #(
    parameter int DATA_W  = 8,
    parameter int PULSE_W = 8,
    parameter int CNT_W   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             b1_flag,
    input logic             err_pulse,
    input logic [CNT_W-1:0] err_cnt
);

    logic [15:0] hi_run;

    // Length of the current or just-ended high interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
        end else if (err_pulse) begin
            hi_run <= hi_run + 1'b1;
        end else begin
            hi_run <= '0;
        end
    end

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt <= CNT_W'(DATA_W));

    p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !b1_flag |=> $stable(err_cnt));

    p_pulse_needs_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (err_cnt != '0));

    p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_pulse && hi_run != '0) |-> (hi_run == 16'(PULSE_W)));

    p_first_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        b1_flag |=> ((err_cnt != '0) == err_pulse));

endmodule

bind sec_parity_chk sec_parity_chk_props #(
    .DATA_W  (DATA_W),
    .PULSE_W (PULSE_W),
    .CNT_W   (CNT_W)
) u_props (
    .clk       (clk),
    .rst_n     (rst_n),
    .b1_flag   (b1_flag),
    .err_pulse (err_pulse),
    .err_cnt   (err_cnt)
);

// File: tb/sec_parity_chk_tb_top.sv
// Bench: drives frames with chosen parity-byte error masks and compares the
// outputs with a behavioural model on every clock.
module sec_parity_chk_tb_top;

    localparam int DW  = 8;
    localparam int PW  = 4;
    localparam int B1P = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          frame_start;
    logic [DW-1:0] scr_data;
    logic [DW-1:0] dsc_data;
    logic          b1_flag;
    logic          err_pulse;
    logic [3:0]    err_cnt;

    int n_cmp  = 0;
    int n_fail = 0;
    bit started = 0;
    bit done = 0;

    // Model state.
    int m_acc, m_ref, m_cnt;
    bit m_seen, m_refok, m_pulse;
    bit q[$];

    // Per-frame observation.
    int rises = 0;
    bit prev_pulse = 0;
    int bench_prev_par = 0;

    always #4 clk = ~clk;

    sec_parity_chk #(.DATA_W(DW), .PULSE_W(PW)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .scr_data    (scr_data),
        .dsc_data    (dsc_data),
        .b1_flag     (b1_flag),
        .err_pulse   (err_pulse),
        .err_cnt     (err_cnt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    endtask

    // Behavioural model, updated on every rising edge.
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_acc = 0; m_ref = 0; m_cnt = 0;
            m_seen = 0; m_refok = 0; m_pulse = 0;
            q.delete();
        end else begin
            if (b1_flag && m_refok) begin
                int n;
                n = 0;
                for (int i = 0; i < DW; i++) n += ((m_ref ^ dsc_data) >> i) & 1;
                m_cnt = n;
                q.delete();
                for (int k = 0; k < n; k++) begin
                    for (int j = 0; j < PW; j++) q.push_back(1'b1);
                    for (int j = 0; j < PW; j++) q.push_back(1'b0);
                end
            end
            if (frame_start) begin
                m_ref = m_acc; m_refok = m_seen; m_seen = 1; m_acc = scr_data;
            end else begin
                m_acc = m_acc ^ scr_data;
            end
            m_pulse = (q.size() > 0) ? q.pop_front() : 1'b0;
        end
    end

    // Every-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            check(err_pulse === m_pulse, "R4 R5 R6 pulse", int'(err_pulse), int'(m_pulse));
            check(err_cnt === 4'(m_cnt), "R3 count", int'(err_cnt), m_cnt);
            if (err_pulse && !prev_pulse) rises++;
            prev_pulse = err_pulse;
        end
    end

    // Sends one frame; mask flips bits of the true parity in the parity byte.
    task automatic send_frame(input int len, input int mask, input string req, input int exp_n);
        int par;
        par = 0;
        rises = 0;
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            frame_start = (i == 0);
            scr_data    = DW'($urandom);
            par         = par ^ scr_data;
            b1_flag     = (i == B1P);
            dsc_data    = (i == B1P) ? DW'(bench_prev_par ^ mask) : DW'($urandom);
        end
        @(negedge clk);
        // Frame-level pulse count (R4) and the count reported in this frame.
        check(rises == exp_n, req, rises, exp_n);
        check(err_cnt == 4'(exp_n) || exp_n == 0, req, int'(err_cnt), exp_n);
        bench_prev_par = par;
    endtask

    initial begin
        rst_n = 0; frame_start = 0; scr_data = 0; dsc_data = 0; b1_flag = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: outputs quiet during reset.
        check(err_pulse == 1'b0, "R9 reset pulse", int'(err_pulse), 0);
        check(err_cnt == 4'd0, "R9 reset count", int'(err_cnt), 0);
        @(posedge clk); #1;
        rst_n = 1;
        // R7: junk bytes before the first frame, with a stray parity flag.
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #1;
            scr_data = DW'($urandom);
            dsc_data = DW'($urandom);
            b1_flag  = (i == 4);
        end
        // R8: first frame, its parity byte must give no report.
        send_frame(80, 8'hFF, "R8 first frame", 0);
        check(err_cnt == 4'd0, "R8 count stays zero", int'(err_cnt), 0);
        // R1 R2: matching parity, no pulses.
        send_frame(80, 8'h00, "R4 zero errors", 0);
        send_frame(72, 8'h01, "R2 single low bit", 1);
        send_frame(90, 8'h80, "R1 single high bit", 1);
        send_frame(80, 8'h5A, "R4 four bits", 4);
        send_frame(85, 8'hFF, "R4 eight bits", 8);
        // R7: short frame after a long one; seeding must drop old bytes.
        send_frame(75, 8'h00, "R7 seeded frame", 0);
        send_frame(80, 8'h13, "R5 three pulses", 3);
        // R9: reset again mid-stream clears the report.
        @(posedge clk); #1;
        rst_n = 0; frame_start = 0; b1_flag = 0;
        @(posedge clk); #1;
        rst_n = 1;
        @(negedge clk);
        check(err_cnt == 4'd0, "R9 reset clears count", int'(err_cnt), 0);
        bench_prev_par = 0;
        send_frame(80, 8'hAA, "R8 first frame after reset", 0);
        send_frame(80, 8'h0F, "R2 after reset", 4);
        repeat (4) @(posedge clk);
        finish_run();
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule